// File: doc/BRIEF.md
# ADC multi-channel scan sequencer

This block is the digital side of a multi-channel analog-to-digital converter. It runs a scan: it visits each channel that a bitmask selects, from the lowest number upward. For each channel it asks the converter for one conversion, waits for the converter's done strobe, and passes on the result tagged with its channel number. A one-cycle completion pulse follows the last channel of the scan.

A scan is launched in one of two ways: by the chosen edge of one of several hardware trigger lines, or by a software start strobe. The selected trigger line is normally resynchronised by a flip-flop chain before its edge is detected. A bypass option removes that chain for triggers that are already synchronous, which cuts the trigger-to-start delay. The configuration port follows a protective rule. While the sequence is enabled, the channel mask, the trigger select and the polarity are frozen. They change only while the sequence is disabled, or in the same write that enables it.

Top module: `adc_scan_seq`

## Requirements
- R1: Mask bit n selects channel n. A scan converts exactly the channels whose mask bits are 1, one result per channel.
- R2: Within a scan, channels are converted in ascending order, starting at the lowest enabled channel.
- R3: The 3-bit trigger select value k makes hardware trigger input k, and no other input, able to launch a scan.
- R4: Polarity 0 launches on a falling edge of the selected trigger and polarity 1 on a rising edge. The opposite edge launches nothing.
- R5: A software start strobe launches a scan while the sequence is enabled. While it is disabled, the strobe has no effect.
- R6: With bypass 0, a trigger edge driven between clock edges raises conv_req at the third following clock edge. With bypass 1, it rises at the first following clock edge.
- R7: While the sequence is enabled, a configuration write leaves the mask, trigger select and polarity unchanged. A write made while disabled, including one that also sets enable, takes all fields.
- R8: A change of polarity or trigger select made in the write that enables the sequence launches no scan by itself.
- R9: After reset, conv_req, res_valid and scan_done are 0, and the sequence is disabled: mask 0, trigger 0, falling edge, synchronizer in use. Triggers and start strobes do nothing.
- R10: Trigger edges and start strobes that arrive while a scan is running are ignored. They start no second scan.
- R11: scan_done pulses for one cycle, one clock edge after the done strobe of the last channel. A scan with an all-zero mask issues no request and pulses scan_done one clock edge after it is launched.
- R12: One clock edge after each conv_done, res_valid pulses for one cycle with the channel number and the converter's result. conv_chan stays unchanged while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 12 | Channel-enable mask to write |
| cfg_trig_sel | input | 3 | Hardware trigger select to write |
| cfg_trig_pol | input | 1 | Trigger polarity to write (1 = rising) |
| cfg_sync_byp | input | 1 | Synchronizer bypass to write |
| cfg_enable | input | 1 | Sequence enable to write |
| sw_start | input | 1 | Software start strobe |
| hw_trig | input | 8 | Hardware trigger lines |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Channel of the current request |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 12 | Converter result, valid with conv_done |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 4 | Channel of the result |
| res_data | output | 12 | Result value |
| scan_done | output | 1 | End-of-scan pulse |

## Verification
The hardest case to reach from the ports is the write that enables the sequence and, in the same write, flips the polarity or the trigger select. Before the write, the trigger line is parked at a level that becomes "active" under the new setting. The bench then checks that no request appears in the cycles that follow, and that a genuine edge afterwards still launches a scan. A second hard case is a frozen-field write made while enabled. Its only visible effect is the channel order of the next scan, so the bench runs a scan straight after the write and scores the order of the results against the old mask.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_CONV = 1'b1
   } seq_state_t;
endpackage

// File: rtl/adc_scan_cfg.sv
module adc_scan_cfg #(
   parameter int NCHAN  = 12,
   parameter int TSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [NCHAN-1:0]  wr_mask,
   input  logic [TSEL_W-1:0] wr_sel,
   input  logic              wr_pol,
   input  logic              wr_byp,
   input  logic              wr_en,
   output logic [NCHAN-1:0]  mask_q,
   output logic [TSEL_W-1:0] sel_q,
   output logic              pol_q,
   output logic              byp_q,
   output logic              en_q
);
   initial begin
      assert (NCHAN > 0) else $error("NCHAN must be positive");
      assert (TSEL_W > 0) else $error("TSEL_W must be positive");
   end

   logic open_w;
   assign open_w = we & ~en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         sel_q  <= '0;
         pol_q  <= 1'b0;
         byp_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (open_w) begin
            mask_q <= wr_mask;
            sel_q  <= wr_sel;
            pol_q  <= wr_pol;
         end
         if (we) begin
            byp_q <= wr_byp;
            en_q  <= wr_en;
         end
      end
   end

   // R7
   mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_q) |-> ($stable(mask_q) && $stable(sel_q) && $stable(pol_q)));
endmodule

// File: rtl/adc_scan_trig.sv
module adc_scan_trig #(
   parameter int NTRIG       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int TSEL_W     = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NTRIG-1:0]  hw_trig,
   input  logic [TSEL_W-1:0] sel,
   input  logic              pol,
   input  logic              byp,
   input  logic              en,
   output logic              launch
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (NTRIG >= 1) else $error("NTRIG must be at least 1");
   end

   logic [SYNC_STAGES-1:0][NTRIG-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], hw_trig};
   end

   logic cond, lvl, prev_q, arm_q;
   assign cond = byp ? hw_trig[sel] : chain_q[SYNC_STAGES-1][sel];
   assign lvl  = pol ? cond : ~cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         prev_q <= lvl;
         arm_q  <= en;
      end
   end

   assign launch = en & arm_q & lvl & ~prev_q;

   // R4
   single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
   import adc_scan_pkg::*;
#(
   parameter int NCHAN  = 12,
   parameter int RES_W  = 12,
   localparam int CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NCHAN-1:0] mask,
   output logic             conv_req,
   output logic [CH_W-1:0]  conv_chan,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_result,
   output logic             res_valid,
   output logic [CH_W-1:0]  res_chan,
   output logic [RES_W-1:0] res_data,
   output logic             scan_done
);
   function automatic logic [CH_W-1:0] lowest(input logic [NCHAN-1:0] m);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = NCHAN - 1; i >= 0; i--) begin
         if (m[i]) r = CH_W'(i);
      end
      return r;
   endfunction

   seq_state_t       st_q;
   logic [NCHAN-1:0] pend_q, pend_nx;
   logic [CH_W-1:0]  chan_q;

   assign pend_nx = pend_q & ~(NCHAN'(1) << chan_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         pend_q    <= '0;
         chan_q    <= '0;
         res_valid <= 1'b0;
         res_chan  <= '0;
         res_data  <= '0;
         scan_done <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         scan_done <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  if (mask == '0) begin
                     scan_done <= 1'b1;
                  end else begin
                     pend_q <= mask;
                     chan_q <= lowest(mask);
                     st_q   <= SQ_CONV;
                  end
               end
            end
            SQ_CONV: begin
               if (conv_done) begin
                  res_valid <= 1'b1;
                  res_chan  <= chan_q;
                  res_data  <= conv_result;
                  pend_q    <= pend_nx;
                  if (pend_nx == '0) begin
                     st_q      <= SQ_IDLE;
                     scan_done <= 1'b1;
                  end else begin
                     chan_q <= lowest(pend_nx);
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign conv_req  = (st_q == SQ_CONV);
   assign conv_chan = chan_q;

   // R12
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));
   // R12
   res_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(conv_done));
   // R11
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(scan_done && conv_req));
   // R1
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> pend_q[conv_chan]);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int NCHAN       = 12,
   parameter int NTRIG       = 8,
   parameter int RES_W       = 12,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = (NCHAN > 1) ? $clog2(NCHAN) : 1,
   localparam int TSEL_W     = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [NCHAN-1:0]  cfg_mask,
   input  logic [TSEL_W-1:0] cfg_trig_sel,
   input  logic              cfg_trig_pol,
   input  logic              cfg_sync_byp,
   input  logic              cfg_enable,
   input  logic              sw_start,
   input  logic [NTRIG-1:0]  hw_trig,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic              res_valid,
   output logic [CH_W-1:0]   res_chan,
   output logic [RES_W-1:0]  res_data,
   output logic              scan_done
);
   initial begin
      assert (RES_W > 0) else $error("RES_W must be positive");
   end

   logic [NCHAN-1:0]  mask_q;
   logic [TSEL_W-1:0] sel_q;
   logic              pol_q, byp_q, en_q, hw_launch, start;

   adc_scan_cfg #(.NCHAN(NCHAN), .TSEL_W(TSEL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .wr_mask(cfg_mask), .wr_sel(cfg_trig_sel), .wr_pol(cfg_trig_pol),
      .wr_byp(cfg_sync_byp), .wr_en(cfg_enable),
      .mask_q(mask_q), .sel_q(sel_q), .pol_q(pol_q), .byp_q(byp_q), .en_q(en_q)
   );

   adc_scan_trig #(.NTRIG(NTRIG), .SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .sel(sel_q),
      .pol(pol_q), .byp(byp_q), .en(en_q), .launch(hw_launch)
   );

   assign start = hw_launch | (sw_start & en_q);

   adc_scan_fsm #(.NCHAN(NCHAN), .RES_W(RES_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .mask(mask_q),
      .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_result(conv_result), .res_valid(res_valid), .res_chan(res_chan),
      .res_data(res_data), .scan_done(scan_done)
   );

   // R5
   no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !conv_req) |=> !conv_req);
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_mask = '0;
   logic [2:0]  cfg_trig_sel = '0;
   logic        cfg_trig_pol = 1'b0;
   logic        cfg_sync_byp = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        sw_start = 1'b0;
   logic [7:0]  hw_trig = '0;
   logic        conv_req;
   logic [3:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [11:0] conv_result = '0;
   logic        res_valid;
   logic [3:0]  res_chan;
   logic [11:0] res_data;
   logic        scan_done;

   int checks = 0;
   int errors = 0;
   int conv_lat = 2;
   int cyc = 0;
   logic [3:0] exp_q [$];

   always #2.5 clk = ~clk;

   adc_scan_seq u_adc_scan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
      .cfg_trig_sel(cfg_trig_sel), .cfg_trig_pol(cfg_trig_pol),
      .cfg_sync_byp(cfg_sync_byp), .cfg_enable(cfg_enable),
      .sw_start(sw_start), .hw_trig(hw_trig), .conv_req(conv_req),
      .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
      .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
      .scan_done(scan_done)
   );

   function automatic logic [11:0] model_val(input logic [3:0] ch);
      return 12'hA00 | (12'(ch) * 12'd17);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter model
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (conv_req) begin
            if (cnt >= conv_lat) begin
               conv_done   = 1'b1;
               conv_result = model_val(conv_chan);
               cnt = 0;
            end else cnt++;
         end else cnt = 0;
      end
   end

   // monitor / scoreboard (15 marks end of scan)
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (res_valid) begin
            if (exp_q.size() == 0) chk(0, "R10 unexpected result", res_chan, -1);
            else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               chk(res_chan == e, "R1 R2 result channel", res_chan, e);
               chk(res_data == model_val(e), "R12 result data", res_data, model_val(e));
            end
         end
         if (scan_done) begin
            if (exp_q.size() == 0) chk(0, "R11 unexpected scan_done", 0, 15);
            else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               chk(e == 4'd15, "R11 scan_done position", e, 15);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic push_scan(input logic [11:0] m);
      for (int i = 0; i < 12; i++) if (m[i]) exp_q.push_back(4'(i));
      exp_q.push_back(4'd15);
   endtask

   task automatic wcfg(input logic [11:0] m, input logic [2:0] s, input logic p,
                       input logic b, input logic en);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mask = m; cfg_trig_sel = s;
      cfg_trig_pol = p; cfg_sync_byp = b; cfg_enable = en;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while ((exp_q.size() != 0 || conv_req) && n < 500) begin
         @(negedge clk); n++;
      end
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic no_req(input int n, input string req);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (conv_req || res_valid || scan_done) seen = 1;
      end
      chk(!seen, req, seen, 0);
   endtask

   task automatic sw_pulse();
      @(negedge clk); sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
   endtask

   task automatic lat_meas(input logic [7:0] v, input int exp, input string req);
      int n = 0;
      @(negedge clk); hw_trig = v;
      while (!conv_req && n < 20) begin @(negedge clk); n++; end
      chk(n == exp, req, n, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!conv_req && !res_valid && !scan_done, "R9 reset outputs", conv_req, 0);
      rst_n = 1'b1;
      // R9: disabled after reset, strobe and falling edge do nothing
      sw_pulse();
      @(negedge clk); hw_trig = 8'hFF;
      @(negedge clk); hw_trig = 8'h00;
      no_req(8, "R9 disabled after reset");

      // R1 R2 R5 software scan
      wcfg(12'b1010_0010_0101, 3'd0, 1'b0, 1'b0, 1'b1);
      push_scan(12'b1010_0010_0101);
      sw_pulse();
      wait_idle("R1 R2 scan completes");

      // R7 mask write while enabled ignored
      wcfg(12'h003, 3'd5, 1'b1, 1'b0, 1'b1);
      push_scan(12'b1010_0010_0101);
      sw_pulse();
      wait_idle("R7 frozen mask scan");

      // R11 zero mask; R7 write while disabled then enable
      wcfg(12'h000, 3'd0, 1'b0, 1'b0, 1'b0);
      sw_pulse();
      no_req(4, "R5 start ignored while disabled");
      wcfg(12'h000, 3'd0, 1'b0, 1'b0, 1'b1);
      begin
         int n = 0; bit req_seen = 0;
         @(negedge clk); sw_start = 1'b1; exp_q.push_back(4'd15);
         @(negedge clk); sw_start = 1'b0;
         if (conv_req) req_seen = 1;
         chk(exp_q.size() == 0, "R11 zero-mask done next edge", exp_q.size(), 0);
         while (n < 5) begin @(negedge clk); if (conv_req) req_seen = 1; n++; end
         chk(!req_seen, "R11 zero mask no request", req_seen, 0);
      end

      // R3 R4 R6 trigger 3, falling, synchronized
      wcfg(12'h801, 3'd3, 1'b0, 1'b0, 1'b0);
      wcfg(12'h801, 3'd3, 1'b0, 1'b0, 1'b1);
      hw_trig = 8'hFF;
      no_req(6, "R4 rising ignored with polarity 0");
      push_scan(12'h801);
      lat_meas(8'hF7, 3, "R6 R3 synchronized latency");
      wait_idle("R4 falling scan");
      @(negedge clk); hw_trig = 8'hFF;
      @(negedge clk); hw_trig = 8'hFD;
      no_req(6, "R3 other input ignored");
      hw_trig = 8'hFF;
      repeat (4) @(negedge clk);

      // R6 bypass, rising, trigger 6; R8 enable with pol change at active level
      wcfg(12'h040, 3'd6, 1'b0, 1'b1, 1'b0);
      @(negedge clk); hw_trig = 8'h40;
      repeat (3) @(negedge clk);
      wcfg(12'h040, 3'd6, 1'b1, 1'b1, 1'b1);
      no_req(6, "R8 no launch from polarity change");
      @(negedge clk); hw_trig = 8'h00;
      repeat (3) @(negedge clk);
      push_scan(12'h040);
      lat_meas(8'h40, 1, "R6 bypass latency");
      wait_idle("R4 rising scan");

      // R8 select change in enabling write
      wcfg(12'h040, 3'd6, 1'b1, 1'b1, 1'b0);
      @(negedge clk); hw_trig = 8'h04;
      wcfg(12'h040, 3'd2, 1'b1, 1'b1, 1'b1);
      no_req(6, "R8 no launch from select change");
      hw_trig = 8'h00;
      repeat (3) @(negedge clk);

      // R10 triggers during scan ignored
      wcfg(12'hFFF, 3'd2, 1'b1, 1'b0, 1'b0);
      wcfg(12'hFFF, 3'd2, 1'b1, 1'b0, 1'b1);
      push_scan(12'hFFF);
      sw_pulse();
      repeat (6) @(negedge clk);
      hw_trig = 8'h04;
      repeat (4) @(negedge clk);
      sw_pulse();
      hw_trig = 8'h00;
      wait_idle("R10 single scan");
      no_req(10, "R10 no second scan");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule